// File: doc/BRIEF.md
# Pixel Stream Mode and Row Tracker

This control block sits at the front of a raster image engine that receives a square grayscale frame one pixel at a time. It keeps the operating mode of the engine, which is reset, idle or busy, and drives it on a two-bit output. It counts the accepted pixels so that the line buffer knows which column and which buffer row to write next. It also reports the row of the pixel it received last.

A frame holds 2^COL_W × 2^ROW_W pixels. The default is 8 bits each, so 256 × 256 = 65536 pixels. Pixels arrive as single-cycle strobes on `pix_vld`. The first accepted pixel moves the block from idle to busy. Once the last pixel of the frame has been accepted, the block waits for the datapath to pulse `res_last`, which marks its final result, and then drops back to idle. The pixel data and the edge arithmetic live elsewhere. This block handles only sequencing and position.

Top module: `pxs_ctrl`

## Requirements
- R1: `mode_o` encodes the state as 2'b01 = reset, 2'b10 = idle and 2'b11 = busy. The all-zero power-up state shows 2'b00 and leaves it only through reset.
- R2: When `rst` is high at a rising edge, `mode_o` is 2'b01 from the next cycle on and stays there while `rst` stays high. The same edge clears `wr_col_o`, `wr_row_o` and `row_o` to 0.
- R3: In the cycle after `rst` is sampled low in reset mode, `mode_o` becomes 2'b10 (idle).
- R4: A `pix_vld` strobe in idle is accepted as pixel (column 0, row 0), and `mode_o` is 2'b11 in the next cycle.
- R5: While `rst` is high, and in the power-up state, `pix_vld` and `res_last` have no effect on any output.
- R6: Each accepted pixel advances `wr_col_o` by one. At 2^COL_W−1 it wraps to 0 and advances `wr_row_o`, which also wraps, so both read 0 after the final pixel.
- R7: `row_o` gives the row of the most recently accepted pixel. It changes only when a pixel is accepted, and reads 2^ROW_W−1 after the final pixel.
- R8: Busy mode holds until `res_last` is seen at or after the acceptance of the final pixel, and this includes `res_last` in the same cycle as the final pixel. Idle follows in the next cycle. Any `res_last` seen earlier, or in idle, is ignored.
- R9: Strobes on `pix_vld` after the final pixel and before `res_last` are not accepted. `row_o`, `wr_col_o` and `wr_row_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_vld | input | 1 | Single-cycle strobe: a pixel is present |
| res_last | input | 1 | Datapath strobe: final result of the frame emitted |
| mode_o | output | 2 | Operating mode (R1 encoding) |
| row_o | output | ROW_W | Row of the most recently accepted pixel |
| wr_col_o | output | COL_W | Column for the next pixel write |
| wr_row_o | output | ROW_W | Row for the next pixel write |

## Verification
Two functions can fall into one cycle. One is the acceptance of the frame's final pixel, which wraps both counters and latches the top row. The other is the completion strobe that ends busy mode. The bench drives `res_last` together with the last pixel of a reduced 8 × 8 frame. It then checks that idle appears on the next cycle, that `row_o` reads 7 and that both write indices read 0. A separate run sends the strobe before the frame is complete and sends a spare pixel after it, and checks that neither one disturbs the mode or the position.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
   // state register value equals the mode shown on the port
   typedef enum logic [1:0] {
      ST_PWR  = 2'b00,
      ST_RST  = 2'b01,
      ST_IDLE = 2'b10,
      ST_BUSY = 2'b11
   } pxs_state_e;
endpackage

// File: rtl/pxs_wrap_cnt.sv
module pxs_wrap_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] cnt,
   output logic         at_max
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nx;

   generate
      if (W == 1) begin : g_bit
         always_comb cnt_nx = ~cnt_q;
      end else begin : g_inc
         always_comb cnt_nx = (cnt_q == MAXV) ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr)      cnt_q <= '0;
      else if (adv) cnt_q <= cnt_nx;
   end

   assign cnt    = cnt_q;
   assign at_max = (cnt_q == MAXV);
endmodule

// File: rtl/pxs_mode_fsm.sv
module pxs_mode_fsm
   import pxs_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       pix_vld,
   input  logic       res_last,
   input  logic       last_pos,
   output logic [1:0] mode,
   output logic       accept
);
   pxs_state_e st_q = ST_PWR;
   pxs_state_e st_nx;
   logic       got_all_q = 1'b0;
   logic       last_acc;
   logic       finish;

   always_comb begin
      accept = !rst && pix_vld &&
               ((st_q == ST_IDLE) || ((st_q == ST_BUSY) && !got_all_q));
      last_acc = accept && last_pos;
      finish   = (st_q == ST_BUSY) && res_last && (got_all_q || last_acc);
   end

   always_comb begin
      st_nx = st_q;
      if (rst) begin
         st_nx = ST_RST;
      end else begin
         unique case (st_q)
            ST_PWR:  st_nx = ST_PWR;
            ST_RST:  st_nx = ST_IDLE;
            ST_IDLE: if (accept) st_nx = ST_BUSY;
            ST_BUSY: if (finish) st_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      st_q <= st_nx;
      if (rst || finish)  got_all_q <= 1'b0;
      else if (last_acc)  got_all_q <= 1'b1;
   end

   assign mode = st_q;
endmodule

// File: rtl/pxs_ctrl.sv
module pxs_ctrl #(
   parameter int COL_W = 8,
   parameter int ROW_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pix_vld,
   input  logic             res_last,
   output logic [1:0]       mode_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] wr_col_o,
   output logic [ROW_W-1:0] wr_row_o
);
   generate
      if (COL_W < 1 || COL_W > 16) begin : g_bad_col
         $error("pxs_ctrl: COL_W out of range");
      end
      if (ROW_W < 1 || ROW_W > 16) begin : g_bad_row
         $error("pxs_ctrl: ROW_W out of range");
      end
   endgenerate

   logic             accept;
   logic             col_max;
   logic             row_max;
   logic [COL_W-1:0] col_cnt;
   logic [ROW_W-1:0] row_cnt;
   logic [ROW_W-1:0] row_q;

   pxs_mode_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .pix_vld  (pix_vld),
      .res_last (res_last),
      .last_pos (col_max && row_max),
      .mode     (mode_o),
      .accept   (accept)
   );

   pxs_wrap_cnt #(.W(COL_W)) u_col (
      .clk    (clk),
      .clr    (rst),
      .adv    (accept),
      .cnt    (col_cnt),
      .at_max (col_max)
   );

   pxs_wrap_cnt #(.W(ROW_W)) u_row (
      .clk    (clk),
      .clr    (rst),
      .adv    (accept && col_max),
      .cnt    (row_cnt),
      .at_max (row_max)
   );

   // row of the pixel just taken, held until the next one
   always_ff @(posedge clk) begin
      if (rst)         row_q <= '0;
      else if (accept) row_q <= row_cnt;
   end

   assign row_o    = row_q;
   assign wr_col_o = col_cnt;
   assign wr_row_o = row_cnt;
endmodule

// File: rtl/pxs_ctrl_chk.sv
module pxs_ctrl_chk #(
   parameter int COL_W = 8,
   parameter int ROW_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             pix_vld,
   input logic             res_last,
   input logic [1:0]       mode_o,
   input logic [ROW_W-1:0] row_o,
   input logic [COL_W-1:0] wr_col_o,
   input logic [ROW_W-1:0] wr_row_o
);
   logic rst_q = 1'b0;
   always_ff @(posedge clk) begin
      rst_q <= rst;
      // R2
      if (rst_q) begin
         rst_mode_chk: assert (mode_o == 2'b01 && wr_col_o == '0 &&
                               wr_row_o == '0 && row_o == '0);
      end
   end

   // R1
   pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'b00) |=> (mode_o == 2'b00));

   // R3
   rst_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'b01) |=> (mode_o == 2'b10));

   // R4
   start_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'b10 && pix_vld) |=> (mode_o == 2'b11));

   // R6
   col_step_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'b11 && pix_vld && !(wr_col_o == '0 && wr_row_o == '0))
      |=> (wr_col_o == $past(wr_col_o) + 1'b1));

   // R7
   row_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!pix_vld) |=> $stable(row_o));

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mode_o == 2'b11 && !res_last) |=> (mode_o == 2'b11));
endmodule

bind pxs_ctrl pxs_ctrl_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pix_vld  (pix_vld),
   .res_last (res_last),
   .mode_o   (mode_o),
   .row_o    (row_o),
   .wr_col_o (wr_col_o),
   .wr_row_o (wr_row_o)
);

// File: tb/tb_pxs_ctrl.sv
module tb_pxs_ctrl;
   localparam int CW = 3;
   localparam int RW = 3;
   localparam int NPIX = 1 << (CW + RW);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          pix_vld = 1'b0;
   logic          res_last = 1'b0;
   logic [1:0]    mode_o;
   logic [RW-1:0] row_o;
   logic [CW-1:0] wr_col_o;
   logic [RW-1:0] wr_row_o;

   int checks = 0;
   int fails  = 0;

   pxs_ctrl #(.COL_W(CW), .ROW_W(RW)) dut (
      .clk(clk), .rst(rst), .pix_vld(pix_vld), .res_last(res_last),
      .mode_o(mode_o), .row_o(row_o), .wr_col_o(wr_col_o), .wr_row_o(wr_row_o)
   );

   always #5 clk = ~clk;

   // {rst, pix, last, gap[3:0], mode[1:0], row[2:0], col[2:0], wrrow[2:0]}
   localparam logic [17:0] TBL [0:16] = '{
      {3'b100, 4'd0, 2'b01, 3'd0, 3'd0, 3'd0},
      {3'b110, 4'd0, 2'b01, 3'd0, 3'd0, 3'd0},
      {3'b101, 4'd0, 2'b01, 3'd0, 3'd0, 3'd0},
      {3'b100, 4'd0, 2'b01, 3'd0, 3'd0, 3'd0},
      {3'b100, 4'd0, 2'b01, 3'd0, 3'd0, 3'd0},
      {3'b000, 4'd0, 2'b10, 3'd0, 3'd0, 3'd0},
      {3'b001, 4'd0, 2'b10, 3'd0, 3'd0, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd1, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd2, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd3, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd4, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd5, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd6, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd7, 3'd0},
      {3'b010, 4'd3, 2'b11, 3'd0, 3'd0, 3'd1},
      {3'b010, 4'd3, 2'b11, 3'd1, 3'd1, 3'd1},
      {3'b001, 4'd0, 2'b11, 3'd1, 3'd1, 3'd1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive one cycle; outputs are checked after the following falling edge
   task automatic cyc(input logic r, input logic p, input logic l);
      rst = r; pix_vld = p; res_last = l;
      @(negedge clk);
      pix_vld = 1'b0; res_last = 1'b0;
   endtask

   task automatic idle_n(input int n);
      for (int k = 0; k < n; k++) cyc(rst, 1'b0, 1'b0);
   endtask

   task automatic pos_chk(input string tag, input int m, input int rw,
                          input int c, input int wr);
      chk({tag, " R1 mode"}, mode_o, m);
      chk({tag, " R7 row_o"}, row_o, rw);
      chk({tag, " R6 wr_col"}, wr_col_o, c);
      chk({tag, " R6 wr_row"}, wr_row_o, wr);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // table walk: reset (R2, R5), exit (R3), idle done ignored (R8),
      // start (R4), stepping and wrap (R6, R7), early done ignored (R8)
      for (int i = 0; i < 17; i++) begin
         cyc(TBL[i][17], TBL[i][16], TBL[i][15]);
         pos_chk($sformatf("tbl%0d R2 R3 R4 R5 R8", i), TBL[i][10:9],
                 TBL[i][8:6], TBL[i][5:3], TBL[i][2:0]);
         idle_n(TBL[i][14:11]);
      end

      // rest of frame 1, including one 200-cycle gap
      for (int idx = 9; idx < NPIX; idx++) begin
         cyc(1'b0, 1'b1, 1'b0);
         chk("R7 row of latest pixel", row_o, idx >> CW);
         chk("R6 column", wr_col_o, (idx + 1) % (1 << CW));
         if (idx == 20) begin
            idle_n(200);
            chk("R8 busy across long gap", mode_o, 2'b11);
         end else idle_n(3);
      end
      pos_chk("frame end R7", 2'b11, 7, 0, 0);

      // spare pixel before completion strobe
      cyc(1'b0, 1'b1, 1'b0);
      pos_chk("spare R9", 2'b11, 7, 0, 0);
      idle_n(3);
      cyc(1'b0, 1'b0, 1'b1);
      chk("R8 done after final", mode_o, 2'b10);
      idle_n(3);
      chk("R8 stays idle", mode_o, 2'b10);

      // frame 2: done strobe in the same cycle as the final pixel
      for (int idx = 0; idx < NPIX; idx++) begin
         cyc(1'b0, 1'b1, idx == NPIX - 1);
         if (idx == 0) pos_chk("restart R4", 2'b11, 0, 1, 0);
         idle_n(3);
      end
      pos_chk("same-cycle done R8", 2'b10, 7, 0, 0);

      // frame 3 cut by reset
      for (int idx = 0; idx < 10; idx++) begin
         cyc(1'b0, 1'b1, 1'b0);
         idle_n(3);
      end
      pos_chk("pre-reset R6", 2'b11, 1, 2, 1);
      cyc(1'b1, 1'b0, 1'b0);
      pos_chk("mid-frame reset R2", 2'b01, 0, 0, 0);
      for (int k = 0; k < 4; k++) begin
         cyc(1'b1, 1'b1, 1'b1);
         pos_chk("pixel in reset R5", 2'b01, 0, 0, 0);
      end
      cyc(1'b0, 1'b0, 1'b0);
      pos_chk("release R3", 2'b10, 0, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule